// File: doc/BRIEF.md
# Left-to-Right Scalar Point Multiplier Sequencer

This block runs scalar multiplication Q = k·P on an elliptic curve over a binary field, with points in Jacobian projective form (X, Y, Z). It uses the left-to-right double-and-add method. A start pulse captures an M-bit scalar and a base point. The running point begins at the point at infinity. The block then takes one clock cycle for each scalar bit, starting with the most significant bit.

The group arithmetic sits outside this block. Every cycle, the block presents the running point Q and the captured base point P on its operand ports. An external combined unit returns the doubled point 2Q and the sum 2Q + P in the same cycle. The block decides which of these becomes the next running point. It looks at the current scalar bit and at a two-bit select code taken from the doubled result, which covers the infinity and equality corner cases. After M cycles it pulses `done`. The accumulator then holds k·P and keeps that value until the next start.

Top module: `pmul_seq`

## Requirements
- R1: A `start` seen while idle captures the scalar and base point. `busy` goes high on the next cycle, and the accumulator becomes the point at infinity, X=1, Y=1, Z=0.
- R2: Each run keeps `busy` high for exactly M cycles. `done` is high for one cycle, in the cycle right after the last bit step, and `busy` is low while `done` is high.
- R3: Scalar bits are used from bit M-1 down to bit 0, one per cycle. When the bit is 0, the doubled point becomes the next running point.
- R4: When the bit is 1 and the select code is 00 (doubled point neither infinite nor equal to the base), the added point becomes the next running point.
- R5: When the bit is 1 and the doubled point has Z=0 (select code 01, checked first), the base point becomes the next running point.
- R6: When the bit is 1 and the doubled point matches the base point in X, Y and Z with Z nonzero (select code 10), the doubled point becomes the next running point.
- R7: A `start` that arrives while `busy` is high has no effect on the running computation or on the captured base point.
- R8: Once `done` has pulsed, the accumulator outputs do not change until the next accepted `start`.
- R9: A zero scalar gives the point at infinity (Z=0) after M cycles.
- R10: While busy, the operand ports show the current running point and the captured base point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (taken only when idle) |
| scalar | input | M | Scalar k |
| base_x | input | M | Base point X |
| base_y | input | M | Base point Y |
| base_z | input | M | Base point Z |
| busy | output | 1 | High while the bit steps run |
| done | output | 1 | One-cycle completion pulse |
| acc_x | output | M | Running point X / result X |
| acc_y | output | M | Running point Y / result Y |
| acc_z | output | M | Running point Z / result Z |
| op_px | output | M | Captured base X to the group unit |
| op_py | output | M | Captured base Y to the group unit |
| op_pz | output | M | Captured base Z to the group unit |
| dbl_x | input | M | Doubled point X from the group unit |
| dbl_y | input | M | Doubled point Y from the group unit |
| dbl_z | input | M | Doubled point Z from the group unit |
| add_x | input | M | Sum 2Q+P, X, from the group unit |
| add_y | input | M | Sum 2Q+P, Y, from the group unit |
| add_z | input | M | Sum 2Q+P, Z, from the group unit |

## Verification
Some behaviour is checked by the assertions on every cycle:
- the run length is exactly M busy cycles;
- `done` is a single cycle and never overlaps `busy`;
- an accepted start resets the accumulator to infinity;
- the base point does not move during a run;
- the result holds while idle.

Other behaviour only shows up in the bench's runs against a toy cyclic group:
- whether the scalar bit and the select code pick the right candidate each cycle;
- whether the bit order is correct;
- what a zero scalar produces;
- the equality case, where the stated rule gives a value that differs from the true 2P.

// File: rtl/pmul_seq.sv
module pmul_seq #(
  parameter int M = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] scalar,
  input  logic [M-1:0] base_x,
  input  logic [M-1:0] base_y,
  input  logic [M-1:0] base_z,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] acc_x,
  output logic [M-1:0] acc_y,
  output logic [M-1:0] acc_z,
  output logic [M-1:0] op_px,
  output logic [M-1:0] op_py,
  output logic [M-1:0] op_pz,
  input  logic [M-1:0] dbl_x,
  input  logic [M-1:0] dbl_y,
  input  logic [M-1:0] dbl_z,
  input  logic [M-1:0] add_x,
  input  logic [M-1:0] add_y,
  input  logic [M-1:0] add_z
);
  localparam int CW = (M > 1) ? $clog2(M) : 1;
  localparam int SW = $clog2(M + 1);
  localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

  logic [M-1:0]  k_sh;
  logic [CW-1:0] cnt;
  logic [1:0]    sel;
  logic [M-1:0]  m1_x, m1_y, m1_z, nx_x, nx_y, nx_z;
  logic          accept;

  assign accept = start && !busy;

  assign sel = (dbl_z == '0) ? 2'b01 :
               ((dbl_x == op_px) && (dbl_y == op_py) && (dbl_z == op_pz)) ? 2'b10 : 2'b00;

  always_comb begin
    case (sel)
      2'b01:   {m1_x, m1_y, m1_z} = {op_px, op_py, op_pz};
      2'b10:   {m1_x, m1_y, m1_z} = {dbl_x, dbl_y, dbl_z};
      default: {m1_x, m1_y, m1_z} = {add_x, add_y, add_z};
    endcase
  end

  assign {nx_x, nx_y, nx_z} = k_sh[M-1] ? {m1_x, m1_y, m1_z} : {dbl_x, dbl_y, dbl_z};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      k_sh  <= '0;
      acc_x <= ONE;
      acc_y <= ONE;
      acc_z <= '0;
      op_px <= '0;
      op_py <= '0;
      op_pz <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= CW'(M - 1);
        k_sh  <= scalar;
        acc_x <= ONE;
        acc_y <= ONE;
        acc_z <= '0;
        op_px <= base_x;
        op_py <= base_y;
        op_pz <= base_z;
      end else if (busy) begin
        acc_x <= nx_x;
        acc_y <= nx_y;
        acc_z <= nx_z;
        k_sh  <= k_sh << 1;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  logic [SW-1:0] steps;
  always_ff @(posedge clk) begin
    if (!rst_n)      steps <= '0;
    else if (accept) steps <= '0;
    else if (busy)   steps <= steps + 1'b1;
  end

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps == SW'(M)));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_inf_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && acc_z == '0 && acc_x == ONE && acc_y == ONE));
  assert_base_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_px) && $stable(op_py) && $stable(op_pz)));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(acc_x) && $stable(acc_y) && $stable(acc_z)));
endmodule

// File: tb/pmul_seq_bench.sv
`timescale 1ns/1ps
module pmul_seq_bench;
  localparam int M = 16;
  localparam int ORD = 13;

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] scalar = '0, base_x = '0, base_y = '0, base_z = '0;
  logic busy, done;
  logic [M-1:0] acc_x, acc_y, acc_z, op_px, op_py, op_pz;
  logic [M-1:0] dbl_x, dbl_y, dbl_z, add_x, add_y, add_z;

  always #2.5 clk = ~clk;

  pmul_seq #(.M(M)) u_pmul_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
    .base_x(base_x), .base_y(base_y), .base_z(base_z),
    .busy(busy), .done(done), .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
    .op_px(op_px), .op_py(op_py), .op_pz(op_pz),
    .dbl_x(dbl_x), .dbl_y(dbl_y), .dbl_z(dbl_z),
    .add_x(add_x), .add_y(add_y), .add_z(add_z));

  // Toy cyclic group: multiple n of the generator is (n, n^5A5A, 1), infinity is (1,1,0)
  function automatic logic [3*M-1:0] enc(int n);
    if (n == 0) return {16'd1, 16'd1, 16'd0};
    return {16'(n), 16'(n) ^ 16'h5A5A, 16'd1};
  endfunction
  function automatic int dec(logic [M-1:0] x, logic [M-1:0] z);
    return (z == 0) ? 0 : int'(x);
  endfunction

  always_comb begin
    {dbl_x, dbl_y, dbl_z} = enc((2 * dec(acc_x, acc_z)) % ORD);
    {add_x, add_y, add_z} = enc((2 * dec(acc_x, acc_z) + dec(op_px, op_pz)) % ORD);
  end

  int nvec = 0, nbad = 0;
  logic [3*M-1:0] expq[$];
  bit finished = 0;

  function automatic int model(logic [M-1:0] k, int pb);
    int n = 0;
    for (int i = M - 1; i >= 0; i--) begin
      int d = (2 * n) % ORD;
      if (!k[i])        n = d;        // R3
      else if (d == 0)  n = pb;       // R5
      else if (d == pb) n = d;        // R6
      else              n = (d + pb) % ORD; // R4
    end
    return n;
  endfunction

  task automatic chk(bit ok, string req, logic [3*M-1:0] act, logic [3*M-1:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) chk(0, "R2", {acc_x, acc_y, acc_z}, '0);
      else begin
        logic [3*M-1:0] e;
        e = expq.pop_front();
        chk({acc_x, acc_y, acc_z} == e, "R3/R4/R5/R6/R9", {acc_x, acc_y, acc_z}, e);
      end
    end
  end

  task automatic run(logic [M-1:0] k, int pb, bit poke, string tag);
    logic [3*M-1:0] e;
    int lat;
    e = enc(model(k, pb));
    expq.push_back(e);
    {base_x, base_y, base_z} = enc(pb);
    scalar = k;
    start = 1;
    @(negedge clk);
    start = 0;
    chk({acc_x, acc_y, acc_z} == enc(0) && busy, "R1", {acc_x, acc_y, acc_z}, enc(0));
    lat = 0;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (lat == 3) begin
        chk({op_px, op_py, op_pz} == enc(pb), "R10", {op_px, op_py, op_pz}, enc(pb));
        if (poke) begin
          scalar = ~k;
          {base_x, base_y, base_z} = enc((pb % (ORD - 1)) + 1);
          start = 1;
        end
      end
      if (lat == 4) start = 0;
      if (lat > M + 5) break;
    end
    chk(lat == M && !busy, "R2", 48'(lat), 48'(M));
    if (poke) chk({acc_x, acc_y, acc_z} == e, "R7", {acc_x, acc_y, acc_z}, e);
    repeat (5) @(negedge clk);
    chk({acc_x, acc_y, acc_z} == e && !done, "R8", {acc_x, acc_y, acc_z}, e);
    if (tag.len() > 0) $display("run %s done", tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && acc_z == 0, "R1", {acc_x, acc_y, acc_z}, enc(0));
    rst_n = 1;
    @(negedge clk);
    run(16'h000F, 1, 0, "R6 equality");       // 1,3,7 then 2*7=1=P
    run(16'h0000, 5, 0, "R9 zero");
    run(16'hFFFF, 3, 0, "R4 ones");
    run(16'h8000, 4, 0, "R3 msb");
    run(16'h0001, 7, 0, "R5 lsb");
    run(16'hA5C3, 2, 1, "R7 busy start");
    run(16'h1234, 11, 0, "");
    run(16'hBEEF, 6, 0, "");
    chk(expq.size() == 0, "R2", 48'(expq.size()), 48'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule